// File: doc/BRIEF.md
# Scanout Plane Address Validator

This block turns one framebuffer description into the start addresses a scanout DMA fetches from, and checks each address against the DMA's limits before anything is programmed. The caller presents the base address and byte offset of up to three memory planes, the pitch of each plane, the bytes per pixel of the first plane and of the secondary planes, the chroma subsampling of each axis, the source origin in whole pixels, the frame width and a format class. One start pulse begins a calculation.

Two clock edges later a done pulse appears with the luma start address, the two chroma offsets (unsigned distances from the luma start), the address of a separate alpha plane, a valid flag and a one-hot error code. The outputs hold their values until the next result is delivered.

Top module: `scan_plane_addr`

## Requirements
- R1: A start sampled at one rising edge makes done high for exactly one cycle after the second following edge; done never rises without such a start, and every result output holds its value between done pulses.
- R2: The luma start address is base0 + off0 + pitch0 * y + pix_bytes * x, taken modulo 2^32.
- R3: For class code 1 (semi-planar) and code 2 (planar), the chroma start of plane n (n = 1, 2) is base_n + off_n + pitch_n * cy + chroma_bytes * cx, with cx = x/2 when sub_h is 1 (else x) and cy = y/2 when sub_v is 1 (else y); u_off = chroma start of plane 1 minus luma start, v_off = plane 2 minus luma for planar and equal to u_off for semi-planar; for class code 0 (packed) both offsets are 0.
- R4: For class code 3 (planar with swapped chroma order) u_off carries the plane 2 offset and v_off the plane 1 offset.
- R5: For class code 4 (separate alpha), alpha_addr = base1 + off1 + pitch1 * y + chroma_bytes * x with the unsubsampled origin; for every other class alpha_addr is 0.
- R6: Error bit 0 (alignment) is raised when the luma address, any chroma offset in use, or the alpha address in use is not a multiple of 8.
- R7: Error bit 1 (range) is raised when a chroma offset in use is negative or larger than 0xFFFFF8; 0xFFFFF8 itself is accepted.
- R8: Error bit 2 (pitch) is raised when pitch0, or pitch1 for classes 1 to 4, lies outside 1..16384, or when pitch0 + off0 is less than the frame width rounded up to a multiple of 8 times pix_bytes.
- R9: Error bit 3 (origin) is raised for classes 1 to 3 when sub_h is 1 and x is odd, or sub_v is 1 and y is odd; an odd coordinate on an axis without subsampling is not an error.
- R10: Error bit 4 (pitch mismatch) is raised for classes 2 and 3 when pitch1 differs from pitch2.
- R11: At most one error bit is set, chosen by priority pitch, mismatch, origin, alignment, range; valid is 1 exactly when the error code is 0.
- R12: After reset done, valid and the error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calculation with the current inputs |
| fmt_cls | input | 3 | Format class: 0 packed, 1 semi-planar, 2 planar, 3 planar swapped, 4 separate alpha |
| sub_h | input | 1 | Horizontal chroma subsampling by two |
| sub_v | input | 1 | Vertical chroma subsampling by two |
| src_x | input | 12 | Source origin x in pixels |
| src_y | input | 12 | Source origin y in pixels |
| frame_w | input | 14 | Frame width in pixels |
| pix_bytes | input | 3 | Bytes per pixel of plane 0 |
| chroma_bytes | input | 3 | Bytes per pixel of planes 1 and 2 |
| base0 | input | 32 | Plane 0 base address |
| base1 | input | 32 | Plane 1 base address |
| base2 | input | 32 | Plane 2 base address |
| off0 | input | 32 | Plane 0 byte offset |
| off1 | input | 32 | Plane 1 byte offset |
| off2 | input | 32 | Plane 2 byte offset |
| pitch0 | input | 16 | Plane 0 pitch in bytes |
| pitch1 | input | 16 | Plane 1 pitch in bytes |
| pitch2 | input | 16 | Plane 2 pitch in bytes |
| done | output | 1 | One-cycle result strobe |
| valid | output | 1 | Result passed every check |
| luma_addr | output | 32 | Luma start address |
| u_off | output | 32 | U offset from luma start |
| v_off | output | 32 | V offset from luma start |
| alpha_addr | output | 32 | Alpha plane start address |
| err_code | output | 5 | One-hot error code |

## Verification
Every result of this block, addresses, offsets, valid and error code alike, is due in the same cycle: after the second rising edge that follows the edge sampling start, and nothing arrives earlier. The bench drives inputs and samples outputs on falling edges, confirms done is still low one edge after start, reads all results after the second edge, and confirms done has dropped one edge later while the values stay put.

// File: rtl/scan_plane_pkg.sv
// Shared definitions for the scanout plane address validator.
// Assumes: class codes and error bit positions are fixed by the block's contract.
package scan_plane_pkg;

    typedef enum logic [2:0] {
        FMT_PACKED    = 3'd0,
        FMT_SEMI      = 3'd1,
        FMT_PLANAR    = 3'd2,
        FMT_PLANAR_SW = 3'd3,
        FMT_ALPHA     = 3'd4
    } fmt_e;

    localparam int ERR_W      = 5;
    localparam int ERR_ALIGN  = 0;
    localparam int ERR_RANGE  = 1;
    localparam int ERR_PITCH  = 2;
    localparam int ERR_ORIGIN = 3;
    localparam int ERR_MISM   = 4;

endpackage

// File: rtl/plane_addr.sv
// Start address of one memory plane: base + offset + pitch*y + bytes*x.
// The products and the base sum are registered on load; the final sum is
// combinational from those registers. Assumes modulo-2^ADDR_W arithmetic.
module plane_addr #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int COORD_W = 12,
    parameter int BPP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  off,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [BPP_W-1:0]   bpp,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [ADDR_W-1:0]  addr
);
    localparam int ROW_W = PITCH_W + COORD_W;
    localparam int COL_W = BPP_W + COORD_W;

    logic [ROW_W-1:0]  row_full;
    logic [COL_W-1:0]  col_full;
    logic [ADDR_W-1:0] sum_q, row_q, col_q;

    // Full-width products of the current request.
    always_comb begin
        row_full = ROW_W'(pitch) * ROW_W'(y);
        col_full = COL_W'(bpp) * COL_W'(x);
    end

    // Capture the three address terms when a request is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            sum_q <= base + off;
            row_q <= ADDR_W'(row_full);
            col_q <= ADDR_W'(col_full);
        end
    end

    // Final address from the registered terms.
    assign addr = sum_q + row_q + col_q;

endmodule

// File: rtl/addr_check.sv
// Combinational checks on the computed addresses: offsets from luma,
// alignment, offset range, pitch limits, origin parity, pitch mismatch,
// and priority selection of a single error bit.
// Assumes subsampling factors are 1 or 2 and all inputs are stable.
module addr_check
    import scan_plane_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          PITCH_W   = 16,
    parameter int          FW_W      = 14,
    parameter int          BPP_W     = 3,
    parameter int          MAX_PITCH = 16384,
    parameter logic [31:0] MAX_OFF   = 32'h00FF_FFF8
) (
    input  fmt_e               cls,
    input  logic               hs,
    input  logic               vs,
    input  logic               x_lsb,
    input  logic               y_lsb,
    input  logic [FW_W-1:0]    fw,
    input  logic [BPP_W-1:0]   bpp0,
    input  logic [ADDR_W-1:0]  off0,
    input  logic [PITCH_W-1:0] p0,
    input  logic [PITCH_W-1:0] p1,
    input  logic [PITCH_W-1:0] p2,
    input  logic [ADDR_W-1:0]  luma,
    input  logic [ADDR_W-1:0]  c1,
    input  logic [ADDR_W-1:0]  c2,
    output logic [ADDR_W-1:0]  u_off,
    output logic [ADDR_W-1:0]  v_off,
    output logic [ADDR_W-1:0]  alpha,
    output logic [ERR_W-1:0]   err
);
    localparam int W1 = ADDR_W + 1;

    logic [W1-1:0]   d1, d2, need, have;
    logic [FW_W:0]   fw_rnd;
    logic            is_chroma, is_planar, is_alpha, uses_p1;
    logic            bad1, bad2;
    logic            e_pitch, e_mism, e_orig, e_align, e_range;
    logic [ERR_W-1:0] raw;

    function automatic logic pitch_ok(input logic [PITCH_W-1:0] p);
        return (p != '0) && (32'(p) <= MAX_PITCH);
    endfunction

    // Class decode and signed distances of chroma starts from luma.
    always_comb begin
        is_planar = (cls == FMT_PLANAR) || (cls == FMT_PLANAR_SW);
        is_chroma = is_planar || (cls == FMT_SEMI);
        is_alpha  = (cls == FMT_ALPHA);
        uses_p1   = is_chroma || is_alpha;
        d1 = {1'b0, c1} - {1'b0, luma};
        d2 = {1'b0, c2} - {1'b0, luma};
        bad1 = d1[ADDR_W] || (d1[ADDR_W-1:0] > ADDR_W'(MAX_OFF));
        bad2 = d2[ADDR_W] || (d2[ADDR_W-1:0] > ADDR_W'(MAX_OFF));
    end

    // Route offsets and the alpha address by class.
    always_comb begin
        u_off = '0;
        v_off = '0;
        alpha = '0;
        case (cls)
            FMT_SEMI: begin
                u_off = d1[ADDR_W-1:0];
                v_off = d1[ADDR_W-1:0];
            end
            FMT_PLANAR: begin
                u_off = d1[ADDR_W-1:0];
                v_off = d2[ADDR_W-1:0];
            end
            FMT_PLANAR_SW: begin
                u_off = d2[ADDR_W-1:0];
                v_off = d1[ADDR_W-1:0];
            end
            FMT_ALPHA: alpha = c1;
            default: ;
        endcase
    end

    // Raw error conditions.
    always_comb begin
        fw_rnd = ({1'b0, fw} + (FW_W+1)'(7)) & ~(FW_W+1)'(7);
        need   = W1'(fw_rnd) * W1'(bpp0);
        have   = W1'(p0) + {1'b0, off0};
        e_pitch = !pitch_ok(p0) || (need > have) || (uses_p1 && !pitch_ok(p1));
        e_mism  = is_planar && (p1 != p2);
        e_orig  = is_chroma && ((hs && x_lsb) || (vs && y_lsb));
        e_align = (luma[2:0] != 3'd0)
                || (is_chroma && (d1[2:0] != 3'd0))
                || (is_planar && (d2[2:0] != 3'd0))
                || (is_alpha && (c1[2:0] != 3'd0));
        e_range = (is_chroma && bad1) || (is_planar && bad2);
        raw = '0;
        raw[ERR_PITCH]  = e_pitch;
        raw[ERR_MISM]   = e_mism;
        raw[ERR_ORIGIN] = e_orig;
        raw[ERR_ALIGN]  = e_align;
        raw[ERR_RANGE]  = e_range;
    end

    // Keep only the highest-priority error bit.
    always_comb begin
        err = '0;
        if (raw[ERR_PITCH])       err[ERR_PITCH]  = 1'b1;
        else if (raw[ERR_MISM])   err[ERR_MISM]   = 1'b1;
        else if (raw[ERR_ORIGIN]) err[ERR_ORIGIN] = 1'b1;
        else if (raw[ERR_ALIGN])  err[ERR_ALIGN]  = 1'b1;
        else if (raw[ERR_RANGE])  err[ERR_RANGE]  = 1'b1;
    end

    // R11: the selected code never carries more than one bit.
    always_comb begin
        a_r11_single_err: assert ($onehot0(err));
    end

endmodule

// File: rtl/scan_plane_addr.sv
// Top of the scanout plane address validator. Stage 1 registers the request
// and the per-plane address terms; stage 2 registers checked results and
// pulses done. Assumes start is a single-cycle request; a new start may
// follow every cycle.
module scan_plane_addr
    import scan_plane_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          PITCH_W   = 16,
    parameter int          COORD_W   = 12,
    parameter int          FW_W      = 14,
    parameter int          BPP_W     = 3,
    parameter int          N_PLANES  = 3,
    parameter int          MAX_PITCH = 16384,
    parameter logic [31:0] MAX_OFF   = 32'h00FF_FFF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         fmt_cls,
    input  logic               sub_h,
    input  logic               sub_v,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [FW_W-1:0]    frame_w,
    input  logic [BPP_W-1:0]   pix_bytes,
    input  logic [BPP_W-1:0]   chroma_bytes,
    input  logic [ADDR_W-1:0]  base0,
    input  logic [ADDR_W-1:0]  base1,
    input  logic [ADDR_W-1:0]  base2,
    input  logic [ADDR_W-1:0]  off0,
    input  logic [ADDR_W-1:0]  off1,
    input  logic [ADDR_W-1:0]  off2,
    input  logic [PITCH_W-1:0] pitch0,
    input  logic [PITCH_W-1:0] pitch1,
    input  logic [PITCH_W-1:0] pitch2,
    output logic               done,
    output logic               valid,
    output logic [ADDR_W-1:0]  luma_addr,
    output logic [ADDR_W-1:0]  u_off,
    output logic [ADDR_W-1:0]  v_off,
    output logic [ADDR_W-1:0]  alpha_addr,
    output logic [ERR_W-1:0]   err_code
);
    logic [ADDR_W-1:0]  base_a  [N_PLANES];
    logic [ADDR_W-1:0]  off_a   [N_PLANES];
    logic [PITCH_W-1:0] pitch_a [N_PLANES];
    logic [ADDR_W-1:0]  addr_a  [N_PLANES];

    fmt_e               cls_in, cls_q;
    logic               busy_q, hs_q, vs_q, xl_q, yl_q;
    logic [FW_W-1:0]    fw_q;
    logic [BPP_W-1:0]   bpp0_q;
    logic [ADDR_W-1:0]  off0_q;
    logic [PITCH_W-1:0] p0_q, p1_q, p2_q;
    logic [ADDR_W-1:0]  u_nxt, v_nxt, a_nxt;
    logic [ERR_W-1:0]   err_nxt;

    assign cls_in = fmt_e'(fmt_cls);

    // Gather per-plane inputs into arrays for the generated address units.
    always_comb begin
        base_a[0] = base0;  base_a[1] = base1;  base_a[2] = base2;
        off_a[0]  = off0;   off_a[1]  = off1;   off_a[2]  = off2;
        pitch_a[0] = pitch0; pitch_a[1] = pitch1; pitch_a[2] = pitch2;
    end

    // One address unit per plane; secondary planes use the chroma origin,
    // except the alpha plane, which uses the full-resolution origin.
    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        logic [COORD_W-1:0] px, py;
        logic [BPP_W-1:0]   pb;
        if (p == 0) begin : g_luma
            assign px = src_x;
            assign py = src_y;
            assign pb = pix_bytes;
        end else begin : g_chroma
            assign px = (sub_h && cls_in != FMT_ALPHA) ? (src_x >> 1) : src_x;
            assign py = (sub_v && cls_in != FMT_ALPHA) ? (src_y >> 1) : src_y;
            assign pb = chroma_bytes;
        end
        plane_addr #(
            .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
            .COORD_W(COORD_W), .BPP_W(BPP_W)
        ) u_addr (
            .clk(clk), .rst_n(rst_n), .load(start),
            .base(base_a[p]), .off(off_a[p]), .pitch(pitch_a[p]),
            .bpp(pb), .x(px), .y(py), .addr(addr_a[p])
        );
    end

    // Stage 1: hold the request fields the checks need.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cls_q  <= FMT_PACKED;
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
            xl_q   <= 1'b0;
            yl_q   <= 1'b0;
            fw_q   <= '0;
            bpp0_q <= '0;
            off0_q <= '0;
            p0_q   <= '0;
            p1_q   <= '0;
            p2_q   <= '0;
        end else begin
            busy_q <= start;
            if (start) begin
                cls_q  <= cls_in;
                hs_q   <= sub_h;
                vs_q   <= sub_v;
                xl_q   <= src_x[0];
                yl_q   <= src_y[0];
                fw_q   <= frame_w;
                bpp0_q <= pix_bytes;
                off0_q <= off0;
                p0_q   <= pitch0;
                p1_q   <= pitch1;
                p2_q   <= pitch2;
            end
        end
    end

    addr_check #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .FW_W(FW_W), .BPP_W(BPP_W),
        .MAX_PITCH(MAX_PITCH), .MAX_OFF(MAX_OFF)
    ) u_check (
        .cls(cls_q), .hs(hs_q), .vs(vs_q), .x_lsb(xl_q), .y_lsb(yl_q),
        .fw(fw_q), .bpp0(bpp0_q), .off0(off0_q),
        .p0(p0_q), .p1(p1_q), .p2(p2_q),
        .luma(addr_a[0]), .c1(addr_a[1]), .c2(addr_a[2]),
        .u_off(u_nxt), .v_off(v_nxt), .alpha(a_nxt), .err(err_nxt)
    );

    // Stage 2: register results and strobe done; values hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            valid      <= 1'b0;
            luma_addr  <= '0;
            u_off      <= '0;
            v_off      <= '0;
            alpha_addr <= '0;
            err_code   <= '0;
        end else begin
            done <= busy_q;
            if (busy_q) begin
                valid      <= (err_nxt == '0);
                luma_addr  <= addr_a[0];
                u_off      <= u_nxt;
                v_off      <= v_nxt;
                alpha_addr <= a_nxt;
                err_code   <= err_nxt;
            end
        end
    end

    // R1: a start yields done two edges later.
    a_r1_done_due: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);

    // R1: done only follows a start.
    a_r1_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    // R1: results hold between strobes.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(luma_addr)));

    // R6: an accepted result has an 8-byte aligned luma address.
    a_r6_luma_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (luma_addr[2:0] == 3'd0));

    // R7: an accepted result keeps both offsets within range.
    a_r7_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> ((u_off <= ADDR_W'(MAX_OFF)) && (v_off <= ADDR_W'(MAX_OFF))));

    // R11: at most one error bit on a strobe.
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(err_code));

endmodule

// File: tb/scan_plane_addr_test.sv
// Bench for the scanout plane address validator: a vector table walked by
// one loop, then directed checks for reset, latency, hold and offsets.
module scan_plane_addr_test;

    typedef struct packed {
        logic [2:0]  cls;
        logic        hs;
        logic        vs;
        logic [2:0]  bpp0;
        logic [2:0]  cbpp;
        logic [11:0] x;
        logic [11:0] y;
        logic [13:0] fw;
        logic [15:0] p0;
        logic [15:0] p1;
        logic [15:0] p2;
        logic [31:0] b0;
        logic [31:0] b1;
        logic [31:0] b2;
        logic [4:0]  err;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // 0 R2 packed
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd2,12'd3,14'd64,16'd256,16'd64,16'd64,32'h1000,32'h0,32'h0,5'b00000},
        // 1 R3 semi-planar
        '{3'd1,1'b1,1'b1,3'd1,3'd2,12'd8,12'd2,14'd64,16'd64,16'd64,16'd64,32'h10000,32'h20000,32'h0,5'b00000},
        // 2 R3 planar
        '{3'd2,1'b1,1'b1,3'd1,3'd1,12'd16,12'd4,14'd128,16'd128,16'd64,16'd64,32'h0,32'h8000,32'hA000,5'b00000},
        // 3 R4 planar swapped
        '{3'd3,1'b1,1'b1,3'd1,3'd1,12'd16,12'd4,14'd128,16'd128,16'd64,16'd64,32'h0,32'h8000,32'hA000,5'b00000},
        // 4 R5 separate alpha
        '{3'd4,1'b0,1'b0,3'd2,3'd1,12'd8,12'd1,14'd64,16'd128,16'd64,16'd64,32'h4000,32'h9000,32'h0,5'b00000},
        // 5 R10 pitch mismatch
        '{3'd2,1'b1,1'b1,3'd1,3'd1,12'd16,12'd4,14'd128,16'd128,16'd64,16'd32,32'h0,32'h8000,32'hA000,5'b10000},
        // 6 R9 odd x with horizontal subsampling (beats alignment)
        '{3'd1,1'b1,1'b1,3'd1,3'd2,12'd9,12'd2,14'd64,16'd64,16'd64,16'd64,32'h10000,32'h20000,32'h0,5'b01000},
        // 7 R8 zero pitch
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd2,12'd3,14'd64,16'd0,16'd64,16'd64,32'h1000,32'h0,32'h0,5'b00100},
        // 8 R7 negative offset
        '{3'd2,1'b1,1'b1,3'd1,3'd1,12'd16,12'd4,14'd128,16'd128,16'd64,16'd64,32'h10000,32'h0,32'hA000,5'b00010},
        // 9 R7 offset too large
        '{3'd2,1'b1,1'b1,3'd1,3'd1,12'd16,12'd4,14'd128,16'd128,16'd64,16'd64,32'h0,32'h8000,32'h2000000,5'b00010},
        // 10 R8 pitch at upper limit accepted
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd2,12'd1,14'd64,16'd16384,16'd64,16'd64,32'h0,32'h0,32'h0,5'b00000},
        // 11 R8 pitch one above limit
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd2,12'd1,14'd64,16'd16385,16'd64,16'd64,32'h0,32'h0,32'h0,5'b00100},
        // 12 R6 misaligned alpha
        '{3'd4,1'b0,1'b0,3'd2,3'd1,12'd8,12'd1,14'd64,16'd128,16'd64,16'd64,32'h4000,32'h9004,32'h0,5'b00001},
        // 13 R6 misaligned luma
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd1,12'd3,14'd64,16'd256,16'd64,16'd64,32'h1000,32'h0,32'h0,5'b00001},
        // 14 R8 width rounded to 8 exceeds pitch
        '{3'd0,1'b0,1'b0,3'd4,3'd1,12'd2,12'd3,14'd65,16'd256,16'd64,16'd64,32'h1000,32'h0,32'h0,5'b00100},
        // 15 R7 offset exactly 0xFFFFF8 accepted
        '{3'd1,1'b1,1'b1,3'd1,3'd2,12'd0,12'd0,14'd64,16'd64,16'd64,16'd64,32'h0,32'hFFFFF8,32'h0,5'b00000},
        // 16 R7 offset 0x1000000 rejected
        '{3'd1,1'b1,1'b1,3'd1,3'd2,12'd0,12'd0,14'd64,16'd64,16'd64,16'd64,32'h0,32'h1000000,32'h0,5'b00010},
        // 17 R9 odd x without horizontal subsampling: only alignment fails
        '{3'd1,1'b0,1'b1,3'd1,3'd2,12'd3,12'd2,14'd64,16'd64,16'd64,16'd64,32'h10000,32'h20000,32'h0,5'b00001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  fmt_cls = '0;
    logic        sub_h = 1'b0, sub_v = 1'b0;
    logic [11:0] src_x = '0, src_y = '0;
    logic [13:0] frame_w = '0;
    logic [2:0]  pix_bytes = '0, chroma_bytes = '0;
    logic [31:0] base0 = '0, base1 = '0, base2 = '0;
    logic [31:0] off0 = '0, off1 = '0, off2 = '0;
    logic [15:0] pitch0 = '0, pitch1 = '0, pitch2 = '0;
    logic        done, valid;
    logic [31:0] luma_addr, u_off, v_off, alpha_addr;
    logic [4:0]  err_code;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    scan_plane_addr uut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_cls(fmt_cls),
        .sub_h(sub_h), .sub_v(sub_v), .src_x(src_x), .src_y(src_y),
        .frame_w(frame_w), .pix_bytes(pix_bytes), .chroma_bytes(chroma_bytes),
        .base0(base0), .base1(base1), .base2(base2),
        .off0(off0), .off1(off1), .off2(off2),
        .pitch0(pitch0), .pitch1(pitch1), .pitch2(pitch2),
        .done(done), .valid(valid), .luma_addr(luma_addr),
        .u_off(u_off), .v_off(v_off), .alpha_addr(alpha_addr),
        .err_code(err_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Load a vector onto the inputs (offsets set separately).
    task automatic apply(input vec_t v);
        fmt_cls = v.cls; sub_h = v.hs; sub_v = v.vs;
        pix_bytes = v.bpp0; chroma_bytes = v.cbpp;
        src_x = v.x; src_y = v.y; frame_w = v.fw;
        pitch0 = v.p0; pitch1 = v.p1; pitch2 = v.p2;
        base0 = v.b0; base1 = v.b1; base2 = v.b2;
    endtask

    // Issue one start at a falling edge and wait until results are due.
    task automatic fire();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // Reference addresses computed from R2..R5.
    task automatic expect_addr(input vec_t v, output logic [31:0] el,
                               output logic [31:0] eu, output logic [31:0] ev,
                               output logic [31:0] ea);
        logic [31:0] cx, cy, c1, c2, a;
        el = v.b0 + off0 + 32'(v.p0) * 32'(v.y) + 32'(v.bpp0) * 32'(v.x);
        cx = v.hs ? 32'(v.x >> 1) : 32'(v.x);
        cy = v.vs ? 32'(v.y >> 1) : 32'(v.y);
        c1 = v.b1 + off1 + 32'(v.p1) * cy + 32'(v.cbpp) * cx;
        c2 = v.b2 + off2 + 32'(v.p2) * cy + 32'(v.cbpp) * cx;
        a  = v.b1 + off1 + 32'(v.p1) * 32'(v.y) + 32'(v.cbpp) * 32'(v.x);
        eu = '0; ev = '0; ea = '0;
        case (v.cls)
            3'd1: begin eu = c1 - el; ev = c1 - el; end
            3'd2: begin eu = c1 - el; ev = c2 - el; end
            3'd3: begin eu = c2 - el; ev = c1 - el; end
            3'd4: ea = a;
            default: ;
        endcase
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] el, eu, ev, ea;
        logic [31:0] hold_l;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 done after reset", 32'(done), 32'd0);
        check("R12 valid after reset", 32'(valid), 32'd0);
        check("R12 err after reset", 32'(err_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2..R11
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            off0 = '0; off1 = '0; off2 = '0;
            fire();
            expect_addr(VECS[i], el, eu, ev, ea);
            check($sformatf("R1 done vec %0d", i), 32'(done), 32'd1);
            check($sformatf("R11 err code vec %0d", i), 32'(err_code), 32'(VECS[i].err));
            check($sformatf("R11 valid vec %0d", i), 32'(valid), 32'(VECS[i].err == 5'd0));
            check($sformatf("R2 luma vec %0d", i), luma_addr, el);
            check($sformatf("R3 R4 u_off vec %0d", i), u_off, eu);
            check($sformatf("R3 R4 v_off vec %0d", i), v_off, ev);
            check($sformatf("R5 alpha vec %0d", i), alpha_addr, ea);
            @(negedge clk);
        end

        // R1 latency and hold: done low after one edge, high after two,
        // low after three with values unchanged.
        apply(VECS[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 done not early", 32'(done), 32'd0);
        @(negedge clk);
        check("R1 done on time", 32'(done), 32'd1);
        hold_l = luma_addr;
        apply(VECS[0]);
        @(negedge clk);
        check("R1 done single cycle", 32'(done), 32'd0);
        @(negedge clk);
        check("R1 luma held", luma_addr, hold_l);

        // R2 R3 byte offsets enter the start addresses
        apply(VECS[1]);
        off0 = 32'h40; off1 = 32'h80; off2 = 32'h0;
        fire();
        expect_addr(VECS[1], el, eu, ev, ea);
        check("R2 luma with offset", luma_addr, el);
        check("R3 u_off with offset", u_off, eu);
        check("R11 valid with offset", 32'(valid), 32'd1);
        @(negedge clk);

        // R8 offset counts toward width check: fw 65 passes with off0 = 32
        apply(VECS[14]);
        off0 = 32'h20; off1 = '0; off2 = '0;
        fire();
        check("R8 pitch plus offset covers width", 32'(err_code), 32'd0);
        @(negedge clk);

        // R8 secondary pitch out of range for semi-planar
        apply(VECS[1]);
        off0 = '0;
        pitch1 = 16'd0;
        fire();
        check("R8 pitch1 zero", 32'(err_code), 32'b00100);
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule